// File: doc/BRIEF.md
# Bus Write Issue Controller

This block decides in which cycle a processor puts its next write onto a shared address/data system bus. Pending writes come from a write queue through a valid/ready handshake. The external agent paces the traffic with an active-low write-ready input. Each write takes a two-cycle slot. The first cycle is the address cycle, where the command strobe is high and the queue address is on the bus. The second cycle is the data cycle, where the command strobe is low and the data word is on the bus. The active-low bus valid strobe is low in both cycles.

Two pacing modes are selectable.

- **Reissue mode:** write-ready must have been asserted two cycles before an address cycle. The write only counts if ready is still asserted during that address cycle. If ready has gone, the data cycle is skipped, the queue is not popped, and the same entry is driven again on a later address cycle.
- **Pipelined mode:** every address cycle is followed by its data cycle. After ready drops, the controller may still launch one more write, and then it waits until ready returns.

In both modes the fastest rate is one write every two bus cycles. The mode input only takes effect in cycles where the bus is idle.

Top module: `wr_issue_ctrl`

## Requirements
- R1: Two address cycles never occur in consecutive cycles. While write-ready stays asserted and the queue is non-empty, a new address cycle starts exactly two cycles after the previous one.
- R2: In reissue mode, an address cycle in cycle t occurs only if write-ready (wr_rdy_n low) was asserted in cycle t-2.
- R3: In reissue mode, if wr_rdy_n is high during an address cycle, the next cycle is idle (sys_valid_n high). The queue entry stays unpopped, and the next address cycle carries the same address.
- R4: Address cycles drive sys_valid_n=0, sys_cmd=1 and the entry address on sys_ad. Data cycles drive sys_valid_n=0, sys_cmd=0 and the entry data on sys_ad. Completed writes appear in queue order, with no entry lost and none duplicated.
- R5: In pipelined mode, every address cycle is followed by a data cycle whatever the state of write-ready. Since the last cycle t whose ready two cycles earlier (t-2) was asserted, at most one address cycle may start without that condition.
- R6: wr_mode=0 selects reissue mode and wr_mode=1 selects pipelined mode. The input is sampled only in idle cycles (sys_valid_n high). Changes while the bus is busy have no effect on writes in flight or on writes chained behind them.
- R7: wq_ready is high only while wq_valid is high. In reissue mode it is high in an address cycle whose wr_rdy_n is low. In pipelined mode it is high in the cycle just before the address cycle.
- R8: While rst is high and in the first cycle after it, sys_valid_n=1, sys_cmd=0 and wq_ready=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_mode | input | 1 | 0 = reissue mode, 1 = pipelined mode |
| wq_valid | input | 1 | Write queue head is valid |
| wq_addr | input | AW | Address of queue head |
| wq_data | input | DW | Data of queue head |
| wq_ready | output | 1 | Queue head is consumed at this clock edge |
| wr_rdy_n | input | 1 | Active-low write-ready from the external agent |
| sys_valid_n | output | 1 | Active-low bus valid strobe |
| sys_cmd | output | 1 | High in address cycles, low in data cycles |
| sys_ad | output | max(AW,DW) | Multiplexed address/data bus |

## Verification
The bound checker watches several rules on every cycle:

- spacing of address cycles;
- the two-cycle-earlier ready condition in reissue mode;
- an idle cycle after a failed reissue;
- the data cycle that must follow every pipelined address;
- the single extra pipelined write, tracked with its own ready history and counter;
- mode stability across busy cycles;
- pops only when the queue is valid.

Some properties span many cycles and queue entries, so only the bench scenarios can show them. These include in-order delivery without loss or duplication under random write-ready, retried entries reusing the same address, mode changes landing only at idle cycles, and full throughput under steady ready.

// File: rtl/wic_pkg.sv
package wic_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2
    } wic_state_e;

    typedef enum logic {
        MODE_REISSUE = 1'b0,
        MODE_PIPE    = 1'b1
    } wic_mode_e;

    typedef struct packed {
        logic h1;     // write-ready seen asserted one cycle back
        logic extra;  // one launch without ready still permitted
    } rdy_view_t;

    function automatic int unsigned wmax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/wic_rdy_track.sv
module wic_rdy_track
    import wic_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_rdy_n,
    input  logic      launch,
    output rdy_view_t view
);
    logic h1_q;
    logic extra_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            h1_q    <= 1'b0;
            extra_q <= 1'b0;
        end else begin
            h1_q <= ~wr_rdy_n;
            if (h1_q)
                extra_q <= 1'b1;
            else if (launch)
                extra_q <= 1'b0;
        end
    end

    assign view.h1    = h1_q;
    assign view.extra = extra_q;
endmodule

// File: rtl/wic_sequencer.sv
module wic_sequencer
    import wic_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       mode_in,
    input  logic       wq_valid,
    input  logic       wr_rdy_n,
    input  rdy_view_t  view,
    output wic_state_e state,
    output wic_mode_e  mode_q,
    output logic       launch,
    output logic       pop
);
    wic_state_e state_q, state_d;
    wic_mode_e  mode_r, eff_mode;
    logic       rdy_now, may_go;

    always_comb begin
        eff_mode = (state_q == ST_IDLE) ? wic_mode_e'(mode_in) : mode_r;
        rdy_now  = ~wr_rdy_n;
        may_go   = (eff_mode == MODE_REISSUE) ? view.h1 : (view.h1 | view.extra);
        launch   = (state_q != ST_ADDR) && wq_valid && may_go;
        if (eff_mode == MODE_REISSUE)
            pop = (state_q == ST_ADDR) && rdy_now;
        else
            pop = launch;
        case (state_q)
            ST_ADDR: state_d = (eff_mode == MODE_REISSUE && !rdy_now) ? ST_IDLE : ST_DATA;
            default: state_d = launch ? ST_ADDR : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            mode_r  <= MODE_REISSUE;
        end else begin
            state_q <= state_d;
            mode_r  <= eff_mode;
        end
    end

    assign state  = state_q;
    assign mode_q = mode_r;
endmodule

// File: rtl/wic_bus_drv.sv
module wic_bus_drv
    import wic_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned DW = 32,
    parameter int unsigned BW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  wic_state_e    state,
    input  logic          launch,
    input  logic [AW-1:0] wq_addr,
    input  logic [DW-1:0] wq_data,
    output logic          sys_valid_n,
    output logic          sys_cmd,
    output logic [BW-1:0] sys_ad
);
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (launch) begin
            addr_q <= wq_addr;
            data_q <= wq_data;
        end
    end

    always_comb begin
        sys_valid_n = (state == ST_IDLE);
        sys_cmd     = (state == ST_ADDR);
        case (state)
            ST_ADDR: sys_ad = BW'(addr_q);
            ST_DATA: sys_ad = BW'(data_q);
            default: sys_ad = '0;
        endcase
    end
endmodule

// File: rtl/wr_issue_ctrl.sv
module wr_issue_ctrl
    import wic_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned DW = 32,
    localparam int unsigned BW = wmax(AW, DW)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_mode,
    input  logic          wq_valid,
    input  logic [AW-1:0] wq_addr,
    input  logic [DW-1:0] wq_data,
    output logic          wq_ready,
    input  logic          wr_rdy_n,
    output logic          sys_valid_n,
    output logic          sys_cmd,
    output logic [BW-1:0] sys_ad
);
    rdy_view_t  view;
    wic_state_e state;
    wic_mode_e  mode_q;
    logic       launch;
    logic       pop;

    wic_rdy_track u_track (
        .clk      (clk),
        .rst      (rst),
        .wr_rdy_n (wr_rdy_n),
        .launch   (launch),
        .view     (view)
    );

    wic_sequencer u_seq (
        .clk      (clk),
        .rst      (rst),
        .mode_in  (wr_mode),
        .wq_valid (wq_valid),
        .wr_rdy_n (wr_rdy_n),
        .view     (view),
        .state    (state),
        .mode_q   (mode_q),
        .launch   (launch),
        .pop      (pop)
    );

    wic_bus_drv #(.AW(AW), .DW(DW), .BW(BW)) u_drv (
        .clk         (clk),
        .rst         (rst),
        .state       (state),
        .launch      (launch),
        .wq_addr     (wq_addr),
        .wq_data     (wq_data),
        .sys_valid_n (sys_valid_n),
        .sys_cmd     (sys_cmd),
        .sys_ad      (sys_ad)
    );

    assign wq_ready = pop;
endmodule

// File: rtl/wr_issue_ctrl_chk.sv
module wr_issue_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic mode_q,
    input logic wr_rdy_n,
    input logic sys_valid_n,
    input logic sys_cmd,
    input logic wq_valid,
    input logic wq_ready
);
    logic       h1, h2;
    logic [1:0] xcnt;
    logic       is_addr, is_pipe;

    assign is_addr = !sys_valid_n && sys_cmd;
    assign is_pipe = mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            h1   <= 1'b0;
            h2   <= 1'b0;
            xcnt <= 2'd1;
        end else begin
            h1 <= !wr_rdy_n;
            h2 <= h1;
            if (h2)
                xcnt <= 2'd0;
            else if (is_addr && is_pipe && xcnt != 2'd3)
                xcnt <= xcnt + 2'd1;
        end
    end

    AST_NO_BACK_TO_BACK_ADDR: assert property (@(posedge clk) disable iff (rst)
        is_addr |=> !(!sys_valid_n && sys_cmd)); // R1
    AST_RI_READY_EARLY: assert property (@(posedge clk) disable iff (rst)
        (is_addr && !is_pipe) |-> h2); // R2
    AST_RI_FAIL_IDLE: assert property (@(posedge clk) disable iff (rst)
        (is_addr && !is_pipe && wr_rdy_n) |=> sys_valid_n); // R3
    AST_RI_OK_DATA: assert property (@(posedge clk) disable iff (rst)
        (is_addr && !is_pipe && !wr_rdy_n) |=> (!sys_valid_n && !sys_cmd)); // R4
    AST_PIPE_DATA: assert property (@(posedge clk) disable iff (rst)
        (is_addr && is_pipe) |=> (!sys_valid_n && !sys_cmd)); // R5
    AST_PIPE_ONE_EXTRA: assert property (@(posedge clk) disable iff (rst)
        (is_addr && is_pipe && !h2) |-> (xcnt == 2'd0)); // R5
    AST_MODE_HELD_BUSY: assert property (@(posedge clk) disable iff (rst)
        (!sys_valid_n && !$past(sys_valid_n)) |-> $stable(mode_q)); // R6
    AST_POP_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        wq_ready |-> wq_valid); // R7
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (sys_valid_n && !sys_cmd && !wq_ready)); // R8
endmodule

bind wr_issue_ctrl wr_issue_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .mode_q      (mode_q),
    .wr_rdy_n    (wr_rdy_n),
    .sys_valid_n (sys_valid_n),
    .sys_cmd     (sys_cmd),
    .wq_valid    (wq_valid),
    .wq_ready    (wq_ready)
);

// File: tb/wr_issue_ctrl_tb_top.sv
`timescale 1ns/1ps
module wr_issue_ctrl_tb_top;
    localparam int QN = 512;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_mode = 1'b0;
    logic        wr_rdy_n = 1'b1;
    logic        wq_valid;
    logic [31:0] wq_addr, wq_data;
    logic        wq_ready, sys_valid_n, sys_cmd;
    logic [31:0] sys_ad;

    logic [31:0] qa [QN];
    logic [31:0] qd [QN];
    int head = 0, tail = 0, acc = 0;
    int checks = 0, fails = 0;
    bit steady = 0, finished = 0;
    int extra_seen = 0;

    always #4 clk = ~clk;

    assign wq_valid = (head < tail);
    assign wq_addr  = qa[head % QN];
    assign wq_data  = qd[head % QN];

    wr_issue_ctrl dut_i (
        .clk(clk), .rst(rst), .wr_mode(wr_mode),
        .wq_valid(wq_valid), .wq_addr(wq_addr), .wq_data(wq_data),
        .wq_ready(wq_ready), .wr_rdy_n(wr_rdy_n),
        .sys_valid_n(sys_valid_n), .sys_cmd(sys_cmd), .sys_ad(sys_ad)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic push(input int n);
        for (int i = 0; i < n; i++) begin
            qa[tail % QN] = $urandom;
            qd[tail % QN] = $urandom;
            tail++;
        end
    endtask

    // monitor: independent model of the pacing rules
    bit r1 = 0, r2 = 0, prev_addr = 0, prev_pop = 0, pop_pend = 0;
    bit exp_data = 0, last_mode = 0, fail_pend = 0, have_last = 0;
    logic [31:0] fail_addr;
    int extra_cnt = 1, cyc = 0, last_addr_cyc = 0;

    initial begin
        forever begin
            @(negedge clk);
            if (pop_pend) head++;
            pop_pend = 0;
            #3;
            cyc++;
            if (rst) begin
                check(sys_valid_n && !sys_cmd && !wq_ready, "R8 reset quiet",
                      {sys_valid_n, sys_cmd, wq_ready}, 3'b100);
                r1 = 0; r2 = 0; prev_addr = 0; prev_pop = 0; extra_cnt = 1;
                last_mode = wr_mode;
            end else begin
                bit rdy_now, is_addr;
                rdy_now = !wr_rdy_n;
                is_addr = !sys_valid_n && sys_cmd;
                if (r2) extra_cnt = 0;
                if (wq_ready)
                    check(wq_valid, "R7 pop without valid", wq_valid, 1);
                if (prev_addr) begin
                    if (exp_data) begin
                        check(!sys_valid_n && !sys_cmd && sys_ad == qd[acc % QN],
                              "R4 data cycle", sys_ad, qd[acc % QN]);
                        acc++;
                    end else begin
                        check(sys_valid_n, "R3 idle after failed issue", sys_valid_n, 1);
                    end
                end
                if (is_addr) begin
                    check(!prev_addr, "R1 back-to-back address", prev_addr, 0);
                    if (steady && have_last)
                        check(cyc - last_addr_cyc == 2, "R1 full rate spacing",
                              cyc - last_addr_cyc, 2);
                    check(sys_ad == qa[acc % QN], "R4 address order", sys_ad, qa[acc % QN]);
                    if (fail_pend) begin
                        check(sys_ad == fail_addr, "R3 same address reissued", sys_ad, fail_addr);
                        fail_pend = 0;
                    end
                    if (last_mode == 1'b0) begin
                        check(r2, "R2 ready two cycles earlier", r2, 1);
                        check(wq_ready == rdy_now, "R7 reissue pop timing", wq_ready, rdy_now);
                        exp_data = rdy_now;
                        if (!rdy_now) begin
                            fail_pend = 1;
                            fail_addr = sys_ad;
                        end
                    end else begin
                        if (!r2) begin
                            check(extra_cnt == 0, "R5 one extra write only", extra_cnt, 0);
                            extra_cnt++;
                            extra_seen++;
                        end
                        check(prev_pop && !wq_ready, "R7 pipelined pop timing",
                              {prev_pop, wq_ready}, 2'b10);
                        exp_data = 1;
                    end
                    last_addr_cyc = cyc;
                    have_last = 1;
                end
                if (sys_valid_n) last_mode = wr_mode; // R6 mode taken in idle cycles only
                prev_addr = is_addr;
                prev_pop  = wq_ready && wq_valid;
                pop_pend  = prev_pop;
                r2 = r1;
                r1 = rdy_now;
            end
        end
    end

    task automatic drain;
        wr_rdy_n = 1'b0;
        for (int k = 0; k < 2000 && !(head == tail && acc == tail); k++) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1 directed: steady ready, reissue mode
        wr_mode = 1'b0; wr_rdy_n = 1'b0;
        repeat (3) @(negedge clk);
        push(8);
        repeat (2) @(negedge clk);
        steady = 1;
        repeat (10) @(negedge clk);
        steady = 0;
        drain();
        // R2/R3 random ready, reissue mode
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            wr_rdy_n = ($urandom % 100) < 40;
            if (($urandom % 4) == 0 && tail < 90) push(1);
        end
        drain();
        // R5 directed: ready drops for good while queue is full
        wr_mode = 1'b1;
        repeat (3) @(negedge clk);
        push(10);
        repeat (5) @(negedge clk);
        extra_seen = 0;
        wr_rdy_n = 1'b1;
        repeat (12) @(negedge clk);
        check(extra_seen == 1, "R5 exactly one write after ready drop", extra_seen, 1);
        drain();
        // random ready, pipelined mode
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            wr_rdy_n = ($urandom % 100) < 45;
            if (($urandom % 4) == 0 && tail < 190) push(1);
        end
        drain();
        // R6 random mode changes, including while busy
        for (int i = 0; i < 800; i++) begin
            @(negedge clk);
            wr_rdy_n = ($urandom % 100) < 40;
            wr_mode  = $urandom % 2;
            if (($urandom % 3) == 0 && tail < 300) push(1);
        end
        drain();
        check(acc == tail, "R4 no write lost or duplicated", acc, tail);
        check(head == tail, "R4 queue fully consumed", head, tail);
        finish_run();
    end
endmodule